// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block links a clocked host port to an external asynchronous static RAM of 256K words by 16 bits. The host offers one request at a time with a request/ready handshake: an 18-bit word address, a write flag, 16 bits of write data and a 2-bit byte mask. Reads return 16 bits of data with a one-cycle valid strobe. Every memory-side control line is active low and comes straight from a flop: chip select, output enable, write enable and one strobe per byte lane. The data bus is split into an output value, a driver enable and an input value, so that a pad ring can build the tri-state pin.

The RAM has no clock. A parameter sets each pulse width as a number of controller clocks, so the access time, the write pulse and the bus turnaround minimums are met at the chosen clock rate. A write is the window in which chip select, write enable and at least one lane strobe are all low. The controller opens that window and closes it on a single clock edge, and the driver enable drops on the same edge. After every read, output enable stays high for a configurable number of idle cycles before the next access may start, so that the memory has released the bus before any write drives it.

Top module: `sram_byte_ctl`

## Requirements
- R1: During and after reset the controller holds chip select, write enable, output enable and both lane strobes high, keeps its data drivers off, and shows ready high.
- R2: A read accepted on a clock edge drives chip select low, output enable low and write enable high for RD_CYC cycles. Lane strobe bit 0 (data bits 7..0) is low exactly when mask bit 0 is set, and lane strobe bit 1 (data bits 15..8) is low exactly when mask bit 1 is set.
- R3: The read word is captured at the end of the RD_CYC cycles. A lane whose mask bit is clear returns zero. Read-valid is high for exactly one cycle.
- R4: A write accepted on a clock edge holds chip select low, write enable low and output enable high for WR_CYC cycles. The lane strobes follow the mask as in R2, and the write data and address stay on the memory pins for the whole pulse.
- R5: The data drivers are on only while write enable is low, and output enable and write enable are never low in the same cycle.
- R6: After every read, all memory controls stay high for TURN_CYC cycles before the controller is ready again. A cycle with output enable low is never followed directly by a cycle with write enable low.
- R7: Ready is low from the edge that accepts a request until that request completes, and a request presented while ready is low has no effect.
- R8: A write with one mask bit set changes only that byte of the addressed word and leaves the other byte unchanged.
- R9: With a mask of zero, a write drives no lane strobe and leaves memory unchanged, and a read still completes and returns zero with read-valid.
- R10: Read-valid is seen RD_CYC cycles after the accepting edge. Ready returns RD_CYC+TURN_CYC cycles after the accepting edge for a read and WR_CYC cycles after it for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Request presented |
| host_ready | output | 1 | Controller can accept a request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Byte mask, bit 0 = data bits 7..0, bit 1 = data bits 15..8 |
| host_rdata | output | 16 | Read data, unmasked lanes zero |
| host_rvalid | output | 1 | One-cycle read data strobe |
| sram_addr | output | 18 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_lane_n | output | 2 | Lane strobes, active low, bit 0 = low byte |
| sram_dq_out | output | 16 | Data to drive onto the bus |
| sram_dq_drv | output | 1 | Bus driver enable |
| sram_dq_in | input | 16 | Data read from the bus |

## Verification
The assertions check the bus-safety rules on every cycle: output enable and write enable never overlap, the drivers are on only inside a write pulse, a read is never followed directly by a write pulse, write enable never falls without chip select, read-valid never lasts two cycles, and the address holds between requests. Only the bench scenarios can show that data really reaches the right lanes: partial writes that merge into a behavioural memory, masked reads that return zero lanes, a zero-mask write that leaves the word alone, a request ignored while busy, and the exact cycle on which valid and ready appear for each access type.

// File: rtl/sram_ctl_pkg.sv
// Shared types for the asynchronous SRAM byte-lane controller.
package sram_ctl_pkg;
    // Sequencer phases: waiting, read pulse, write pulse, post-read bus release.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_TURN  = 2'd3
    } ctl_phase_e;
endpackage

// File: rtl/sram_ctl_seq.sv
// Control sequencer for the SRAM controller.
// Produces every active-low memory strobe from a flop and counts pulse widths
// in clock cycles. Assumes RD_CYC, WR_CYC and TURN_CYC are all at least 1 and
// that the caller presents a request only while ready is high.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [LANES-1:0] mask,
    output logic             ready,
    output logic             accept,
    output logic             sample,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] lane_n,
    output logic             drive
);
    localparam int MAX_RW = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_C  = (MAX_RW > TURN_CYC) ? MAX_RW : TURN_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    ctl_phase_e       phase;
    logic [CNT_W-1:0] cnt;

    // Handshake decodes taken from the registered phase.
    assign ready  = (phase == PH_IDLE);
    assign accept = req && (phase == PH_IDLE);
    assign sample = (phase == PH_READ) && (cnt == '0);

    // Phase, pulse counter and registered memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            cs_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            lane_n <= '1;
            drive  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        cs_n   <= 1'b0;
                        lane_n <= ~mask;
                        if (wr) begin
                            we_n  <= 1'b0;
                            drive <= 1'b1;
                            cnt   <= CNT_W'(WR_CYC - 1);
                            phase <= PH_WRITE;
                        end else begin
                            oe_n  <= 1'b0;
                            cnt   <= CNT_W'(RD_CYC - 1);
                            phase <= PH_READ;
                        end
                    end
                end
                PH_READ: begin
                    if (cnt == '0) begin
                        cs_n   <= 1'b1;
                        oe_n   <= 1'b1;
                        lane_n <= '1;
                        cnt    <= CNT_W'(TURN_CYC - 1);
                        phase  <= PH_TURN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WRITE: begin
                    if (cnt == '0) begin
                        cs_n   <= 1'b1;
                        we_n   <= 1'b1;
                        lane_n <= '1;
                        drive  <= 1'b0;
                        phase  <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && oe_n && we_n && (&lane_n) && !drive)); // R1

    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready); // R7
endmodule

// File: rtl/sram_ctl_datapath.sv
// Address, write-data and read-capture registers for the SRAM controller.
// Latches the request on accept and captures the bus on sample, zeroing every
// lane whose mask bit was clear. Assumes DW divides evenly into LANES lanes.
module sram_ctl_datapath #(
    parameter int AW    = 18,
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sample,
    input  logic [AW-1:0]    addr_in,
    input  logic [DW-1:0]    wdata_in,
    input  logic [LANES-1:0] mask_in,
    input  logic [DW-1:0]    dq_in,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    dq_out,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    localparam int LW = DW / LANES;

    logic [LANES-1:0] mask_q;

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
            mask_q   <= '0;
        end else if (accept) begin
            mem_addr <= addr_in;
            dq_out   <= wdata_in;
            mask_q   <= mask_in;
        end
    end

    // One-cycle valid strobe marking the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= sample;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Capture one lane, or zero when the lane was not requested.
        always_ff @(posedge clk) begin
            if (!rst_n)      rdata[l*LW +: LW] <= '0;
            else if (sample) rdata[l*LW +: LW] <= mask_q[l] ? dq_in[l*LW +: LW] : '0;
        end
    end

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(mem_addr)); // R4
endmodule

// File: rtl/sram_byte_ctl.sv
// Top of the asynchronous SRAM byte-lane controller.
// Joins the sequencer and datapath and checks bus safety at the pins.
// Assumes an external pad drives sram_dq_out when sram_dq_drv is high.
module sram_byte_ctl #(
    parameter int AW       = 18,
    parameter int DW       = 16,
    parameter int LANES    = 2,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    output logic             host_ready,
    input  logic             host_wr,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_wdata,
    input  logic [LANES-1:0] host_mask,
    output logic [DW-1:0]    host_rdata,
    output logic             host_rvalid,
    output logic [AW-1:0]    sram_addr,
    output logic             sram_cs_n,
    output logic             sram_oe_n,
    output logic             sram_we_n,
    output logic [LANES-1:0] sram_lane_n,
    output logic [DW-1:0]    sram_dq_out,
    output logic             sram_dq_drv,
    input  logic [DW-1:0]    sram_dq_in
);
    logic accept;
    logic sample;

    sram_ctl_seq #(
        .LANES(LANES), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(host_req), .wr(host_wr), .mask(host_mask),
        .ready(host_ready), .accept(accept), .sample(sample),
        .cs_n(sram_cs_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
        .lane_n(sram_lane_n), .drive(sram_dq_drv)
    );

    sram_ctl_datapath #(
        .AW(AW), .DW(DW), .LANES(LANES)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .sample(sample),
        .addr_in(host_addr), .wdata_in(host_wdata), .mask_in(host_mask),
        .dq_in(sram_dq_in), .mem_addr(sram_addr), .dq_out(sram_dq_out),
        .rdata(host_rdata), .rvalid(host_rvalid)
    );

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n)); // R5

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_drv |-> (!sram_we_n && sram_oe_n)); // R5

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |=> sram_we_n); // R6
endmodule

// File: tb/sram_byte_ctl_tb.sv
// Scoreboard bench: tasks drive requests and queue expected read words taken
// from a shadow memory; a monitor pops and compares on each read-valid.
module sram_byte_ctl_tb;
    localparam int AW = 18, DW = 16, LANES = 2;
    localparam int RD = 2, WR = 2, TURN = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [LANES-1:0] mask = '0;
    logic ready, rvalid, cs_n, oe_n, we_n, drv;
    logic [DW-1:0] rdata, dq_out, dq_in;
    logic [AW-1:0] maddr;
    logic [LANES-1:0] lane_n;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] sram_mem [int];
    logic [DW-1:0] ref_mem  [int];
    logic [DW-1:0] rd_word = '0;
    logic prev_oe_low = 1'b0;

    always #4 clk = ~clk;

    sram_byte_ctl #(.AW(AW), .DW(DW), .LANES(LANES), .RD_CYC(RD), .WR_CYC(WR), .TURN_CYC(TURN)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_ready(ready), .host_wr(wr),
        .host_addr(addr), .host_wdata(wdata), .host_mask(mask), .host_rdata(rdata),
        .host_rvalid(rvalid), .sram_addr(maddr), .sram_cs_n(cs_n), .sram_oe_n(oe_n),
        .sram_we_n(we_n), .sram_lane_n(lane_n), .sram_dq_out(dq_out), .sram_dq_drv(drv),
        .sram_dq_in(dq_in)
    );

    // Behavioural memory: writes inside the window, reads lag by half a clock.
    always @(negedge clk) begin
        logic [DW-1:0] w;
        w = sram_mem.exists(int'(maddr)) ? sram_mem[int'(maddr)] : '0;
        if (!cs_n && !we_n) begin
            if (!lane_n[0]) w[7:0]  = dq_out[7:0];
            if (!lane_n[1]) w[15:8] = dq_out[15:8];
            sram_mem[int'(maddr)] = w;
        end
        rd_word <= w;
    end
    assign dq_in[7:0]  = (!cs_n && we_n && !oe_n && !lane_n[0]) ? rd_word[7:0]  : 8'hzz;
    assign dq_in[15:8] = (!cs_n && we_n && !oe_n && !lane_n[1]) ? rd_word[15:8] : 8'hzz;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Scoreboard monitor: compare each returned word against the queue head.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rvalid", 32'(rdata), 32'h0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rdata === e, "R3 read data", 32'(rdata), 32'(e));
            end
        end
    end

    // Bus-safety monitor (R5, R6) sampled every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(drv && we_n) && !(!oe_n && !we_n), "R5 driver/oe/we overlap",
                {29'b0, drv, oe_n, we_n}, 32'h3);
            chk(!(prev_oe_low && !we_n), "R6 write straight after read", {31'b0, we_n}, 32'h1);
            prev_oe_low <= !oe_n;
        end
    end

    function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] m);
        logic [DW-1:0] w;
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d; mask = m;
        w = ref_rd(a);
        if (m[0]) w[7:0]  = d[7:0];
        if (m[1]) w[15:8] = d[15:8];
        ref_mem[int'(a)] = w;
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= WR + 1; k++) begin
            if (k == 1) begin
                chk(!cs_n && !we_n && oe_n, "R4 write strobes", {29'b0, cs_n, we_n, oe_n}, 32'h1);
                chk(lane_n == ~m, "R4 lane strobes", 32'(lane_n), 32'(~m));
                chk(drv && dq_out == d && maddr == a, "R4 data and address", 32'(dq_out), 32'(d));
                chk(!ready, "R7 busy after accept", 32'(ready), 32'h0);
            end
            if (k == WR) chk(!we_n && !ready, "R10 write pulse width", {30'b0, we_n, ready}, 32'h0);
            if (k == WR + 1) chk(ready && we_n && !drv, "R10 write completes",
                                 {29'b0, ready, we_n, drv}, 32'h6);
            if (k < WR + 1) @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m, input bit poke);
        logic [DW-1:0] e;
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a; mask = m;
        e = ref_rd(a);
        if (!m[0]) e[7:0]  = '0;
        if (!m[1]) e[15:8] = '0;
        exp_q.push_back(e);
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= RD + TURN + 1; k++) begin
            if (k == 1) begin
                chk(!cs_n && !oe_n && we_n, "R2 read strobes", {29'b0, cs_n, oe_n, we_n}, 32'h1);
                chk(lane_n == ~m, "R2 lane strobes", 32'(lane_n), 32'(~m));
            end
            if (k == RD) chk(!oe_n && !rvalid, "R2 read pulse width", {30'b0, oe_n, rvalid}, 32'h0);
            if (k == RD + 1) begin
                chk(rvalid, "R10 read latency", 32'(rvalid), 32'h1);
                chk(oe_n && we_n && cs_n && lane_n == 2'b11, "R6 turnaround idle",
                    {28'b0, oe_n, we_n, lane_n}, 32'hF);
            end
            if (k == RD + TURN) chk(!ready, "R7 busy until turnaround ends", 32'(ready), 32'h0);
            if (k == RD + TURN + 1) chk(ready, "R10 read ready return", 32'(ready), 32'h1);
            if (poke && k == 1) begin
                req = 1'b1; wr = 1'b1; addr = 18'h00020; wdata = 16'hDEAD; mask = 2'b11;
            end
            if (poke && k == 2) req = 1'b0;
            if (k < RD + TURN + 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready && cs_n && oe_n && we_n && lane_n == 2'b11 && !drv, "R1 reset state",
            {26'b0, ready, cs_n, oe_n, we_n, lane_n}, 32'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && cs_n && oe_n && we_n && !drv, "R1 idle after reset",
            {28'b0, ready, cs_n, oe_n, we_n}, 32'hF);

        do_write(18'h00010, 16'hA5C3, 2'b11);   // R4 full word
        do_read (18'h00010, 2'b11, 1'b0);      // R2 R3
        do_write(18'h00010, 16'h1234, 2'b01);   // R8 low lane only
        do_read (18'h00010, 2'b11, 1'b0);
        do_write(18'h3FFFF, 16'h1111, 2'b11);
        do_write(18'h3FFFF, 16'hBEEF, 2'b10);   // R8 high lane only
        do_read (18'h3FFFF, 2'b11, 1'b0);
        do_read (18'h00010, 2'b01, 1'b0);      // R3 masked lanes zero
        do_read (18'h00010, 2'b10, 1'b0);
        do_write(18'h00010, 16'hFFFF, 2'b00);   // R9 zero-mask write
        do_read (18'h00010, 2'b11, 1'b0);
        do_read (18'h00010, 2'b00, 1'b0);      // R9 zero-mask read
        do_write(18'h00020, 16'h0101, 2'b11);
        do_read (18'h00040, 2'b11, 1'b1);      // R7 request while busy ignored
        do_read (18'h00020, 2'b11, 1'b0);
        for (int i = 1; i < 9; i++) begin      // R6 read/write interleave
            do_write(AW'(i * 37), DW'(i * 16'h1357), 2'(i));
            do_read (AW'(i * 37), 2'b11, 1'b0);
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all reads returned", 32'(exp_q.size()), 32'h0);
        report();
    end
endmodule